// File: doc/BRIEF.md
# Programmable Wait-State Cycle Calculator

This block turns a 16-bit timing configuration word into per-region wait counts. It then prices each memory access that a requester presents. Three request kinds are priced: single 16-bit or 32-bit accesses, sequential or not, and word bursts of N words. For the three cartridge windows and the save-RAM region, the wait counts come from small lookup tables indexed by packed configuration fields. The 32-bit costs are built from two 16-bit halves. A prefetch-enable bit drops the instruction-fetch wait of the cartridge windows to zero. The fixed work-RAM region always has its own wait counts, and every other region costs a single cycle.

A request is a valid/ready transfer. It is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for as long as the stall countdown runs, so a requester that holds `req_valid` high simply waits. Once a request is accepted, the block registers its cycle cost on `cost_o` and raises `stall_o` for exactly that many cycles. It pulses `done_o` in the last of them. The requester drops or changes its request only after acceptance.

Region numbering on `req_region`:

| Region | Kind |
| --- | --- |
| 2 | work RAM |
| 8–9 | cartridge window 0 |
| 10–11 | cartridge window 1 |
| 12–13 | cartridge window 2 |
| 14–15 | save RAM |
| 0, 1, 3 to 7 | plain |

Top module: `ws_cycle_calc`

## Requirements
- R1: After reset, `req_ready` is 1 and `stall_o`, `done_o` and `cost_o` are 0. The configuration word is 0, which gives a cartridge non-sequential 16-bit wait of 4 and sequential 16-bit waits of 2, 4 and 8 for windows 0, 1 and 2.
- R2: Each cartridge window w (0, 1, 2) has a 2-bit non-sequential select at config bits [3w+3:3w+2]. The select values 0, 1, 2, 3 give a 16-bit non-sequential wait of 4, 3, 2, 8.
- R3: Each cartridge window w has a sequential select at config bit 3w+4. A 1 gives a sequential 16-bit wait of 1. A 0 gives 2, 4 or 8 for window 0, 1 or 2.
- R4: For a cartridge window, the 32-bit sequential wait is 2·seq16+1 and the 32-bit non-sequential wait is nonseq16+1+seq16.
- R5: Save RAM (regions 14 and 15) takes its wait from config bits [1:0] through the 4, 3, 2, 8 table. The sequential flag does not change it. The 32-bit wait is 2·v+1.
- R6: Work RAM (region 2) always waits 2 for 16-bit accesses and 5 for 32-bit accesses. Regions 0, 1 and 3 to 7 wait 0. The configuration affects neither.
- R7: A single access costs 1 + the wait selected by the width flag (`req_wide`, 1 = 32-bit) and the sequential flag.
- R8: A burst (`req_burst` = 1) of N words costs (1+nonseq32) + (N−1)·(1+seq32). N = 0 counts as 1. The width, sequential and fetch flags are ignored for bursts.
- R9: When config bit 14 is set, a fetch access (`req_fetch` = 1) to a cartridge window has wait 0. Non-fetch accesses, bursts and other regions are unchanged. When bit 14 is clear, fetch accesses cost the same as normal accesses.
- R10: After acceptance, `stall_o` is high for exactly `cost_o` cycles. `req_ready` is low during those cycles and `done_o` is high only in the last of them.
- R11: A configuration write takes effect from the next accepted request. A request accepted in the same cycle as the write uses the old configuration, and a write during a stall leaves the running count unchanged.
- R12: Config bits 11, 12, 13 and 15 have no effect on any cost.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted (no stall running) |
| req_region | input | 4 | Region number of the access |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| req_seq | input | 1 | 1 = sequential access |
| req_fetch | input | 1 | 1 = instruction-fetch access |
| req_burst | input | 1 | 1 = burst of req_words 32-bit words |
| req_words | input | WORDS_W | Burst length N |
| cost_o | output | COST_W | Cycle cost of the last accepted request |
| stall_o | output | 1 | Stall countdown running |
| done_o | output | 1 | Last stall cycle |

## Verification
Directed cases walk every non-sequential select value in each cartridge window and both sequential values. This separates the field positions of the three windows and the per-window sequential tables, and the 32-bit cases expose any mix-up between the two derivation formulas. Save-RAM, work-RAM and plain-region requests show whether the configuration leaks into regions it must not touch. Fetch requests with prefetch on and off separate the execution-path override from the normal path. Bursts of 0, 1 and many words check both the formula and the zero-length rule. Writes placed in the accept cycle and in the middle of a stall pin down when a new configuration takes effect. A long seeded random mix of configurations and requests then compares each cost and stall length against the bench model.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int REGIONS = 16;
  localparam int WAIT_W  = 5;
  localparam int CFG_W   = 16;
  localparam int PF_BIT  = 14;

  typedef struct packed {
    logic [WAIT_W-1:0] ns16;
    logic [WAIT_W-1:0] s16;
    logic [WAIT_W-1:0] ns32;
    logic [WAIT_W-1:0] s32;
  } waits_t;

  function automatic logic [WAIT_W-1:0] ns_lut(input logic [1:0] sel);
    case (sel)
      2'd0:    ns_lut = WAIT_W'(4);
      2'd1:    ns_lut = WAIT_W'(3);
      2'd2:    ns_lut = WAIT_W'(2);
      default: ns_lut = WAIT_W'(8);
    endcase
  endfunction

  function automatic logic [WAIT_W-1:0] seq_lut(input int win, input logic fast);
    seq_lut = fast ? WAIT_W'(1) : WAIT_W'(2 << win);
  endfunction

  function automatic logic is_cart(input logic [3:0] r);
    is_cart = (r >= 4'd8) && (r <= 4'd13);
  endfunction
endpackage

// File: rtl/ws_timing_table.sv
module ws_timing_table
  import ws_pkg::*;
#(
  parameter int N_REG = REGIONS
) (
  input  logic [CFG_W-1:0]       cfg,
  output waits_t [N_REG-1:0]     tbl
);
  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    localparam bit IS_CART = (g >= 8) && (g <= 13);
    localparam bit IS_SAVE = (g == 14) || (g == 15);
    localparam bit IS_XRAM = (g == 2);
    localparam int WIN     = IS_CART ? (g - 8) / 2 : 0;
    localparam int NS_LO   = 2 + 3 * WIN;
    localparam int SQ_BIT  = 4 + 3 * WIN;

    if (IS_CART) begin : g_cart
      logic [WAIT_W-1:0] ns, sq;
      always_comb begin
        ns = ns_lut(cfg[NS_LO +: 2]);
        sq = seq_lut(WIN, cfg[SQ_BIT]);
        tbl[g].ns16 = ns;
        tbl[g].s16  = sq;
        tbl[g].ns32 = ns + sq + WAIT_W'(1);
        tbl[g].s32  = (sq << 1) + WAIT_W'(1);
      end
    end else if (IS_SAVE) begin : g_save
      logic [WAIT_W-1:0] v;
      always_comb begin
        v = ns_lut(cfg[1:0]);
        tbl[g].ns16 = v;
        tbl[g].s16  = v;
        tbl[g].ns32 = (v << 1) + WAIT_W'(1);
        tbl[g].s32  = (v << 1) + WAIT_W'(1);
      end
    end else if (IS_XRAM) begin : g_xram
      assign tbl[g] = '{ns16: WAIT_W'(2), s16: WAIT_W'(2),
                        ns32: WAIT_W'(5), s32: WAIT_W'(5)};
    end else begin : g_plain
      assign tbl[g] = '0;
    end
  end
endmodule

// File: rtl/ws_cost_calc.sv
module ws_cost_calc
  import ws_pkg::*;
#(
  parameter int COST_W  = 12,
  parameter int WORDS_W = 6
) (
  input  waits_t [REGIONS-1:0] tbl,
  input  logic                 pf_en,
  input  logic [3:0]           region,
  input  logic                 wide,
  input  logic                 seq,
  input  logic                 fetch,
  input  logic                 burst,
  input  logic [WORDS_W-1:0]   words,
  output logic [COST_W-1:0]    cost
);
  waits_t            w;
  logic [WAIT_W-1:0] single_wait;
  logic [COST_W-1:0] n_minus1;
  logic [COST_W-1:0] first_cost, rest_cost;

  always_comb begin
    w = tbl[region];
    case ({wide, seq})
      2'b00:   single_wait = w.ns16;
      2'b01:   single_wait = w.s16;
      2'b10:   single_wait = w.ns32;
      default: single_wait = w.s32;
    endcase
    if (fetch && pf_en && is_cart(region)) single_wait = '0;

    n_minus1   = (words == '0) ? '0 : COST_W'(words) - COST_W'(1);
    first_cost = COST_W'(w.ns32) + COST_W'(1);
    rest_cost  = n_minus1 * (COST_W'(w.s32) + COST_W'(1));

    if (burst) cost = first_cost + rest_cost;
    else       cost = COST_W'(single_wait) + COST_W'(1);
  end
endmodule

// File: rtl/ws_stall_counter.sv
module ws_stall_counter #(
  parameter int COST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [COST_W-1:0] load_val,
  output logic              busy,
  output logic              last
);
  logic [COST_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - COST_W'(1);
  end

  assign busy = (cnt != '0);
  assign last = (cnt == COST_W'(1));
endmodule

// File: rtl/ws_cycle_calc.sv
module ws_cycle_calc
  import ws_pkg::*;
#(
  parameter int COST_W  = 12,
  parameter int WORDS_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [15:0]        cfg_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [3:0]         req_region,
  input  logic               req_wide,
  input  logic               req_seq,
  input  logic               req_fetch,
  input  logic               req_burst,
  input  logic [WORDS_W-1:0] req_words,
  output logic [COST_W-1:0]  cost_o,
  output logic               stall_o,
  output logic               done_o
);
  localparam logic [CFG_W-1:0] USED_MASK = 16'h47FF;

  logic [CFG_W-1:0]     cfg_q;
  waits_t [REGIONS-1:0] tbl;
  logic [COST_W-1:0]    cost_next;
  logic                 accept;
  logic                 busy;
  logic                 unused_cfg;

  assign unused_cfg = ^{cfg_wdata[15], cfg_wdata[13:11], cfg_q[15], cfg_q[13:11]};

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata & USED_MASK;
  end

  ws_timing_table #(.N_REG(REGIONS)) u_tbl (
    .cfg (cfg_q),
    .tbl (tbl)
  );

  ws_cost_calc #(.COST_W(COST_W), .WORDS_W(WORDS_W)) u_cost (
    .tbl    (tbl),
    .pf_en  (cfg_q[PF_BIT]),
    .region (req_region),
    .wide   (req_wide),
    .seq    (req_seq),
    .fetch  (req_fetch),
    .burst  (req_burst),
    .words  (req_words),
    .cost   (cost_next)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)      cost_o <= '0;
    else if (accept) cost_o <= cost_next;
  end

  ws_stall_counter #(.COST_W(COST_W)) u_stall (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (cost_next),
    .busy     (busy),
    .last     (done_o)
  );

  assign stall_o = busy;
endmodule

// File: rtl/ws_cycle_calc_chk.sv
module ws_cycle_calc_chk #(
  parameter int COST_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              stall_o,
  input logic              done_o,
  input logic [COST_W-1:0] cost_o
);
  assert_ready_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> !req_ready);

  assert_accept_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> stall_o);

  assert_done_in_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> stall_o);

  assert_stall_ends_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_o) |-> $past(done_o));

  assert_cost_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(cost_o));

  assert_cost_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (cost_o != '0));
endmodule

bind ws_cycle_calc ws_cycle_calc_chk #(.COST_W(COST_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .stall_o   (stall_o),
  .done_o    (done_o),
  .cost_o    (cost_o)
);

// File: tb/ws_cycle_calc_tb.sv
module ws_cycle_calc_tb;
  localparam int COST_W  = 12;
  localparam int WORDS_W = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [15:0] cfg_wdata = '0;
  logic req_valid = 0;
  logic req_ready;
  logic [3:0] req_region = '0;
  logic req_wide = 0, req_seq = 0, req_fetch = 0, req_burst = 0;
  logic [WORDS_W-1:0] req_words = '0;
  logic [COST_W-1:0] cost_o;
  logic stall_o, done_o;

  int total = 0;
  int bad = 0;
  logic [15:0] m_cfg = '0;

  always #5 clk = ~clk;

  ws_cycle_calc #(.COST_W(COST_W), .WORDS_W(WORDS_W)) u_dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nsv(input logic [1:0] s);
    int t[4] = '{4, 3, 2, 8};
    return t[s];
  endfunction

  function automatic int exp_cost(input logic [15:0] c, input logic [3:0] rg,
                                  input bit wd, input bit sq, input bit ft,
                                  input bit bu, input int nw);
    int a16, b16, a32, b32, w, n, win;
    bit cart;
    a16 = 0; b16 = 0; a32 = 0; b32 = 0; cart = 0;
    if (rg == 2) begin
      a16 = 2; b16 = 2; a32 = 5; b32 = 5;
    end else if (rg >= 8 && rg <= 13) begin
      cart = 1;
      win = (rg - 8) / 2;
      a16 = nsv(c[2 + 3*win +: 2]);
      b16 = c[4 + 3*win] ? 1 : (win == 0 ? 2 : (win == 1 ? 4 : 8));
      a32 = a16 + 1 + b16;
      b32 = 2 * b16 + 1;
    end else if (rg >= 14) begin
      a16 = nsv(c[1:0]); b16 = a16; a32 = 2 * a16 + 1; b32 = a32;
    end
    if (bu) begin
      n = (nw == 0) ? 1 : nw;
      return (1 + a32) + (n - 1) * (1 + b32);
    end
    w = wd ? (sq ? b32 : a32) : (sq ? b16 : a16);
    if (ft && c[14] && cart) w = 0;
    return 1 + w;
  endfunction

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    m_cfg = v;
  endtask

  task automatic issue(input logic [3:0] rg, input bit wd, input bit sq, input bit ft,
                       input bit bu, input int nw, input bit wr_same, input bit wr_mid,
                       input logic [15:0] wv, input string tag);
    int e, n, dpos;
    e = exp_cost(m_cfg, rg, wd, sq, ft, bu, nw);
    @(negedge clk);
    check(req_ready == 1, {tag, " R10 ready before accept"}, req_ready, 1);
    req_valid = 1; req_region = rg; req_wide = wd; req_seq = sq;
    req_fetch = ft; req_burst = bu; req_words = WORDS_W'(nw);
    if (wr_same) begin cfg_we = 1; cfg_wdata = wv; end
    @(negedge clk);
    req_valid = 0;
    cfg_we = 0;
    if (wr_same) m_cfg = wv;
    check(int'(cost_o) == e, {tag, " cost"}, cost_o, e);
    check(req_ready == 0, {tag, " R10 ready low in stall"}, req_ready, 0);
    n = 0; dpos = 0;
    while (stall_o && n < 5000) begin
      n++;
      if (done_o) dpos = n;
      if (wr_mid && n == 1) begin cfg_we = 1; cfg_wdata = wv; end
      @(negedge clk);
      if (wr_mid && n == 1) begin cfg_we = 0; m_cfg = wv; end
    end
    check(n == e, {tag, " R10 stall length"}, n, e);
    check(dpos == e, {tag, " R10 done position"}, dpos, e);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1, "R1 ready", req_ready, 1);
    check(stall_o == 0, "R1 stall", stall_o, 0);
    check(done_o == 0, "R1 done", done_o, 0);
    check(cost_o == 0, "R1 cost", cost_o, 0);
    // R1 reset timing: 16-bit nonseq 4 -> 5, seq 2/4/8 -> 3/5/9
    issue(4'd8,  0, 0, 0, 0, 0, 0, 0, 0, "R1 w0 ns16");
    issue(4'd9,  0, 1, 0, 0, 0, 0, 0, 0, "R1 w0 s16");
    issue(4'd11, 0, 1, 0, 0, 0, 0, 0, 0, "R1 w1 s16");
    issue(4'd12, 0, 1, 0, 0, 0, 0, 0, 0, "R1 w2 s16");
    issue(4'd13, 1, 1, 0, 0, 0, 0, 0, 0, "R4 w2 s32 reset");
    issue(4'd10, 1, 0, 0, 0, 0, 0, 0, 0, "R4 w1 ns32 reset");
    // R2 every nonseq select in each window
    for (int s = 0; s < 4; s++) begin
      write_cfg(16'((s << 2) | (s << 5) | (s << 8)));
      issue(4'd8,  0, 0, 0, 0, 0, 0, 0, 0, "R2 w0");
      issue(4'd10, 0, 0, 0, 0, 0, 0, 0, 0, "R2 w1");
      issue(4'd13, 1, 0, 0, 0, 0, 0, 0, 0, "R2 R4 w2 ns32");
    end
    // R3 sequential fast bits
    write_cfg(16'h0490);
    issue(4'd8,  0, 1, 0, 0, 0, 0, 0, 0, "R3 w0 fast");
    issue(4'd10, 0, 1, 0, 0, 0, 0, 0, 0, "R3 w1 fast");
    issue(4'd12, 1, 1, 0, 0, 0, 0, 0, 0, "R3 R4 w2 fast s32");
    // R5 save RAM
    for (int s = 0; s < 4; s++) begin
      write_cfg(16'(s));
      issue(4'd14, 0, 1, 0, 0, 0, 0, 0, 0, "R5 save s16");
      issue(4'd15, 1, 0, 0, 0, 0, 0, 0, 0, "R5 save ns32");
    end
    // R6 fixed regions regardless of config
    write_cfg(16'h47FF);
    issue(4'd2, 0, 0, 0, 0, 0, 0, 0, 0, "R6 xram 16");
    issue(4'd2, 1, 1, 0, 0, 0, 0, 0, 0, "R6 xram 32");
    issue(4'd0, 1, 0, 1, 0, 0, 0, 0, 0, "R6 plain r0");
    issue(4'd7, 0, 1, 0, 0, 0, 0, 0, 0, "R6 plain r7");
    // R9 prefetch enabled (bit14 set above)
    issue(4'd9,  1, 0, 1, 0, 0, 0, 0, 0, "R9 fetch cart zero");
    issue(4'd9,  1, 0, 0, 0, 0, 0, 0, 0, "R9 nonfetch cart");
    issue(4'd14, 0, 0, 1, 0, 0, 0, 0, 0, "R9 fetch save");
    issue(4'd11, 0, 0, 1, 1, 3, 0, 0, 0, "R9 R8 burst ignores fetch");
    write_cfg(16'h07FF);
    issue(4'd9, 1, 0, 1, 0, 0, 0, 0, 0, "R9 fetch prefetch off");
    // R8 bursts
    write_cfg(16'h0000);
    issue(4'd8,  1, 1, 0, 1, 0, 0, 0, 0, "R8 burst N0");
    issue(4'd8,  0, 0, 0, 1, 1, 0, 0, 0, "R8 burst N1");
    issue(4'd12, 0, 1, 0, 1, 63, 0, 0, 0, "R8 burst N63");
    issue(4'd2,  0, 0, 0, 1, 5, 0, 0, 0, "R8 burst xram");
    // R7 single cost
    issue(4'd3, 0, 0, 0, 0, 0, 0, 0, 0, "R7 minimal cost");
    // R11 same-cycle write uses old config, then new applies
    issue(4'd12, 0, 0, 0, 0, 0, 1, 0, 16'h0300, "R11 same-cycle write");
    issue(4'd12, 0, 0, 0, 0, 0, 0, 0, 0, "R11 new config applies");
    issue(4'd13, 1, 1, 0, 1, 20, 0, 1, 16'h0000, "R11 mid-stall write");
    issue(4'd12, 0, 0, 0, 0, 0, 0, 0, 0, "R11 after mid write");
    // R12 reserved bits
    write_cfg(16'hB800);
    issue(4'd8,  0, 0, 0, 0, 0, 0, 0, 0, "R12 w0");
    issue(4'd12, 1, 1, 1, 0, 0, 0, 0, 0, "R12 w2 no prefetch");
    issue(4'd14, 0, 0, 0, 0, 0, 0, 0, 0, "R12 save");
    // R7 random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 7) == 0) write_cfg(16'($urandom));
      issue(4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            ($urandom_range(0, 3) == 0), $urandom_range(0, 63),
            ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0),
            16'($urandom), "R7 random");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule